// File: doc/BRIEF.md
# Serial EEPROM Access Controller

This controller connects a small set of host-side registers to an external byte-wide EEPROM. The EEPROM is reached through a request/acknowledge port. The host can read or write single bytes through three registers: an address register, a data register and a two-bit request register. Each request bit clears itself when its transfer completes, so the host polls the request bits to learn when a single access is done.

A burst request streams a sequence of records out of the EEPROM. Each record is three bytes: a 16-bit target address sent high byte first, then one data byte. For each record the controller issues one write on an on-chip memory port with a 24-bit address. The top 9 bits of that address come from a base register. The low 15 bits come from the record, and the record's most significant address bit is dropped. A record whose address word is 0xFFFF ends the burst.

The controller remembers the EEPROM address that follows the last byte it touched. The first burst after reset starts at EEPROM address 0. Every later burst starts where the previous single access or burst left off.

Top module: `ee_access_ctrl`

## Requirements
- R1: After reset, ctl_q, burst_q, addr_q, data_q and base_q read 0, and ee_req and mem_we are low.
- R2: Writing ctl_q bit 1 (read request) while idle fetches one byte from EEPROM address addr_q with ee_we low. The byte appears in data_q in the cycle after ee_ack, and in the same cycle ctl_q returns to 0.
- R3: Writing ctl_q bit 0 (write request) while idle stores data_q into EEPROM address addr_q with ee_we high. Bit 0 returns to 0 in the cycle after ee_ack.
- R4: A control write with both bit 0 and bit 1 set performs a read. No EEPROM write takes place.
- R5: While any operation is in progress, writes to the control, burst, address, data and base registers are ignored.
- R6: Writing burst_wdata bit 0 while idle starts a burst. burst_q reads 1 until the terminating record has been fetched, then returns to 0 by itself.
- R7: The first burst after reset starts at EEPROM address 0. Any later burst starts at the address after the last EEPROM byte accessed by a single transfer or by a burst, including a terminator byte.
- R8: Each burst record is read as address high byte, address low byte, then data byte. One cycle after the data byte's ee_ack, mem_we pulses for one cycle with mem_addr = {base_q[8:0], address[14:0]} and mem_wdata = the data byte. Address bit 15 is ignored.
- R9: A record whose address word equals 0xFFFF ends the burst. That record causes no memory write and has no data byte. Address word 0x7FFF is an ordinary record.
- R10: Only bits [7:0] of data_wdata are stored. Those low 8 bits are what an EEPROM write sends.
- R11: ee_req stays high with a stable ee_addr until ee_ack arrives. ee_req falls only in the cycle after an ee_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Write strobe for the request register |
| ctl_wdata | input | 2 | Request bits: bit 0 write, bit 1 read |
| addr_wr | input | 1 | Write strobe for the EEPROM address register |
| addr_wdata | input | EE_AW (16) | EEPROM address |
| data_wr | input | 1 | Write strobe for the data register |
| data_wdata | input | HW (32) | Data value; only bits [7:0] kept |
| base_wr | input | 1 | Write strobe for the burst base register |
| base_wdata | input | BASE_W (9) | Upper memory address bits for bursts |
| burst_wr | input | 1 | Write strobe for the burst-start register |
| burst_wdata | input | 1 | Burst start bit |
| ctl_q | output | 2 | Pending request bits |
| addr_q | output | EE_AW (16) | Address register |
| data_q | output | 8 | Data register |
| base_q | output | BASE_W (9) | Base register |
| burst_q | output | 1 | Burst in progress |
| ee_req | output | 1 | EEPROM transfer request |
| ee_we | output | 1 | EEPROM transfer is a write |
| ee_addr | output | EE_AW (16) | EEPROM byte address |
| ee_wdata | output | 8 | EEPROM write byte |
| ee_ack | input | 1 | EEPROM transfer done, one-cycle pulse |
| ee_rdata | input | 8 | EEPROM read byte, valid with ee_ack |
| mem_we | output | 1 | On-chip memory write pulse |
| mem_addr | output | MEM_AW (24) | On-chip memory address |
| mem_wdata | output | 8 | On-chip memory write byte |

## Verification
The request state becomes visible one cycle after a register strobe. At that point ee_req, ee_addr, ee_we and the request or burst bit are already valid. data_q and the cleared request bits follow one cycle after the cycle in which ee_ack is high, and a memory write pulse follows one cycle after the data byte's ee_ack. The bench drives strobes on falling edges and waits for the falling edge on which ee_ack is seen. It checks that the request bits are still set there and have cleared, with the new data, on the next falling edge. A scoreboard queue holds the expected memory writes and rejects any pulse that is not preceded by an acknowledge.

// File: rtl/ee_access_ctrl.sv
module ee_access_ctrl #(
  parameter int HW     = 32,
  parameter int EE_AW  = 16,
  parameter int BASE_W = 9,
  parameter int MEM_AW = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [1:0]        ctl_wdata,
  input  logic              addr_wr,
  input  logic [EE_AW-1:0]  addr_wdata,
  input  logic              data_wr,
  input  logic [HW-1:0]     data_wdata,
  input  logic              base_wr,
  input  logic [BASE_W-1:0] base_wdata,
  input  logic              burst_wr,
  input  logic              burst_wdata,
  output logic [1:0]        ctl_q,
  output logic [EE_AW-1:0]  addr_q,
  output logic [7:0]        data_q,
  output logic [BASE_W-1:0] base_q,
  output logic              burst_q,
  output logic              ee_req,
  output logic              ee_we,
  output logic [EE_AW-1:0]  ee_addr,
  output logic [7:0]        ee_wdata,
  input  logic              ee_ack,
  input  logic [7:0]        ee_rdata,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [7:0]        mem_wdata
);
  localparam int LOW_W = MEM_AW - BASE_W;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WR, S_BHI, S_BLO, S_BDAT} st_t;

  st_t              st_q;
  logic [EE_AW-1:0] ptr_q, nxt_q;
  logic [7:0]       hi_q, lo_q;
  logic [15:0]      rec;
  logic             busy, start_rd, start_wr, start_bu;
  logic             unused_bits;

  assign busy     = (st_q != S_IDLE);
  assign start_rd = !busy && ctl_wr && ctl_wdata[1];
  assign start_wr = !busy && ctl_wr && ctl_wdata[0] && !ctl_wdata[1];
  assign start_bu = !busy && !(ctl_wr && |ctl_wdata) && burst_wr && burst_wdata;
  assign rec      = {hi_q, lo_q};

  assign ctl_q    = {st_q == S_RD, st_q == S_WR};
  assign burst_q  = (st_q == S_BHI) || (st_q == S_BLO) || (st_q == S_BDAT);
  assign ee_req   = busy;
  assign ee_we    = (st_q == S_WR);
  assign ee_addr  = ptr_q;
  assign ee_wdata = data_q;

  assign unused_bits = ^{data_wdata[HW-1:8], rec[15:LOW_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      ptr_q     <= '0;
      nxt_q     <= '0;
      addr_q    <= '0;
      data_q    <= '0;
      base_q    <= '0;
      hi_q      <= '0;
      lo_q      <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (!busy) begin
        if (addr_wr) addr_q <= addr_wdata;
        if (data_wr) data_q <= data_wdata[7:0];
        if (base_wr) base_q <= base_wdata;
      end
      if (busy && ee_ack) begin
        ptr_q <= ptr_q + 1'b1;
        nxt_q <= ptr_q + 1'b1;
      end
      case (st_q)
        S_IDLE: begin
          if (start_rd) begin
            st_q  <= S_RD;
            ptr_q <= addr_q;
          end else if (start_wr) begin
            st_q  <= S_WR;
            ptr_q <= addr_q;
          end else if (start_bu) begin
            st_q  <= S_BHI;
            ptr_q <= nxt_q;
          end
        end
        S_RD: if (ee_ack) begin
          data_q <= ee_rdata;
          st_q   <= S_IDLE;
        end
        S_WR: if (ee_ack) st_q <= S_IDLE;
        S_BHI: if (ee_ack) begin
          hi_q <= ee_rdata;
          st_q <= S_BLO;
        end
        S_BLO: if (ee_ack) begin
          lo_q <= ee_rdata;
          st_q <= ({hi_q, ee_rdata} == 16'hFFFF) ? S_IDLE : S_BDAT;
        end
        S_BDAT: if (ee_ack) begin
          mem_we    <= 1'b1;
          mem_addr  <= {base_q, rec[LOW_W-1:0]};
          mem_wdata <= ee_rdata;
          st_q      <= S_BHI;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_req && !ee_ack) |=> (ee_req && $stable(ee_addr)));

  p_req_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ee_req) |-> $past(ee_ack));

  p_req_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_ack && (ctl_q != 2'b00)) |=> (ctl_q == 2'b00));

  p_mem_after_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(ee_ack));

  p_mem_base_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[MEM_AW-1:LOW_W] == base_q));

  p_single_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl_q, burst_q}));
endmodule

// File: tb/tb_ee_access_ctrl.sv
`timescale 1ns/1ps
module tb_ee_access_ctrl;
  localparam int LAT = 6;
  localparam int W_CTL = 0, W_ADDR = 1, W_DATA = 2, W_BASE = 3, W_BURST = 4;

  logic clk = 0, rst_n = 0;
  logic ctl_wr = 0, addr_wr = 0, data_wr = 0, base_wr = 0, burst_wr = 0, burst_wdata = 0;
  logic [1:0] ctl_wdata = 0;
  logic [15:0] addr_wdata = 0;
  logic [31:0] data_wdata = 0;
  logic [8:0] base_wdata = 0;
  logic [1:0] ctl_q;
  logic [15:0] addr_q, ee_addr;
  logic [7:0] data_q, ee_wdata, mem_wdata;
  logic [8:0] base_q;
  logic burst_q, ee_req, ee_we, mem_we;
  logic ee_ack = 0;
  logic [7:0] ee_rdata = 0;
  logic [23:0] mem_addr;

  ee_access_ctrl dut (.clk, .rst_n, .ctl_wr, .ctl_wdata, .addr_wr, .addr_wdata,
    .data_wr, .data_wdata, .base_wr, .base_wdata, .burst_wr, .burst_wdata,
    .ctl_q, .addr_q, .data_q, .base_q, .burst_q, .ee_req, .ee_we, .ee_addr,
    .ee_wdata, .ee_ack, .ee_rdata, .mem_we, .mem_addr, .mem_wdata);

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [7:0] eem [0:511];
  logic [31:0] exp_q [$];
  int cnt = 0;
  logic prev_ack = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    ee_ack <= 1'b0;
    if (ee_req && !ee_ack) begin
      if (cnt == LAT) begin
        ee_ack <= 1'b1;
        cnt <= 0;
        if (ee_we) eem[ee_addr[8:0]] <= ee_wdata;
        else ee_rdata <= eem[ee_addr[8:0]];
      end else cnt <= cnt + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      chk(prev_ack, "R8 mem write one cycle after ack", 0, 1);
      if (exp_q.size() == 0) chk(0, "R8 unexpected mem write", {mem_addr, mem_wdata}, 0);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk({mem_addr, mem_wdata} == e, "R8 mem write addr/data", {mem_addr, mem_wdata}, e);
      end
    end
    prev_ack = ee_ack;
  end

  task automatic host_wr(input int which, input logic [31:0] v);
    @(negedge clk);
    case (which)
      W_CTL:   begin ctl_wr = 1; ctl_wdata = v[1:0]; end
      W_ADDR:  begin addr_wr = 1; addr_wdata = v[15:0]; end
      W_DATA:  begin data_wr = 1; data_wdata = v; end
      W_BASE:  begin base_wr = 1; base_wdata = v[8:0]; end
      default: begin burst_wr = 1; burst_wdata = v[0]; end
    endcase
    @(negedge clk);
    ctl_wr = 0; addr_wr = 0; data_wr = 0; base_wr = 0; burst_wr = 0;
  endtask

  task automatic wait_ack(input string tag);
    for (int i = 0; i < 100 && !ee_ack; i++) @(negedge clk);
    chk(ee_ack, tag, ee_ack, 1);
  endtask

  task automatic wait_idle(input string tag);
    for (int i = 0; i < 3000 && (ctl_q != 0 || burst_q); i++) @(negedge clk);
    chk(ctl_q == 0 && !burst_q, tag, {ctl_q, burst_q}, 0);
  endtask

  task automatic do_read(input logic [15:0] a, input logic [1:0] bits, input string tag);
    logic [7:0] e;
    e = eem[a[8:0]];
    host_wr(W_ADDR, a);
    host_wr(W_CTL, bits);
    chk(ctl_q == 2'b10 && !ee_we && ee_addr == a, {tag, " read issued"}, {ctl_q, ee_we, ee_addr}, {2'b10, 1'b0, a});
    wait_ack({tag, " ack"});
    chk(ctl_q == 2'b10, {tag, " bit held until ack"}, ctl_q, 2'b10);
    @(negedge clk);
    chk(ctl_q == 0, {tag, " bit self-clears"}, ctl_q, 0);
    chk(data_q == e, {tag, " data"}, data_q, e);
  endtask

  task automatic burst(input logic [15:0] start, input string tag);
    host_wr(W_BURST, 1);
    chk(burst_q && ee_addr == start && !ee_we, {tag, " start address"}, {burst_q, ee_addr}, {1'b1, start});
  endtask

  task automatic plant(input int a, input logic [15:0] w, input logic [7:0] d);
    eem[a] = w[15:8]; eem[a+1] = w[7:0]; eem[a+2] = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) eem[i] = 8'(i * 13 + 7);
    plant(0, 16'h9234, 8'hA5);
    plant(3, 16'h0005, 8'h3C);
    eem[6] = 8'hFF; eem[7] = 8'hFF;
    plant(22, 16'h0102, 8'h77);
    plant(25, 16'h7FFF, 8'h11);
    eem[28] = 8'hFF; eem[29] = 8'hFF;
    eem[101] = 8'hFF; eem[102] = 8'hFF;
    eem[103] = 8'hFF; eem[104] = 8'hFF;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ctl_q == 0 && !burst_q, "R1 request bits", {ctl_q, burst_q}, 0);
    chk(addr_q == 0 && data_q == 0 && base_q == 0, "R1 registers", {addr_q, data_q, base_q}, 0);
    chk(!ee_req && !mem_we, "R1 outputs", {ee_req, mem_we}, 0);
    rst_n = 1;
    @(negedge clk);

    // R6 R7 R8 R9 first burst from 0, with busy writes ignored (R5)
    host_wr(W_BASE, 9'h1AB);
    exp_q.push_back({9'h1AB, 15'h1234, 8'hA5});
    exp_q.push_back({9'h1AB, 15'h0005, 8'h3C});
    burst(16'd0, "R7 first burst at 0");
    host_wr(W_BASE, 9'h055);
    host_wr(W_CTL, 2'b10);
    chk(ctl_q == 0 && burst_q, "R5 read request ignored during burst", {ctl_q, burst_q}, 3'b001);
    wait_idle("R6 burst bit self-clears");
    chk(base_q == 9'h1AB, "R5 base write ignored while busy", base_q, 9'h1AB);
    chk(exp_q.size() == 0, "R9 burst ends at 0xFFFF", exp_q.size(), 0);
    repeat (3) @(negedge clk);
    chk(!ee_req && !mem_we, "R9 no activity after terminator", {ee_req, mem_we}, 0);

    // R2 single read
    do_read(16'd20, 2'b10, "R2");

    // R5 busy ignore during single read
    begin
      logic [7:0] old40;
      old40 = eem[40];
      host_wr(W_ADDR, 40);
      host_wr(W_CTL, 2'b10);
      host_wr(W_ADDR, 99);
      host_wr(W_CTL, 2'b01);
      host_wr(W_BURST, 1);
      host_wr(W_DATA, 32'h11);
      wait_idle("R5 read completes");
      chk(addr_q == 40, "R5 addr write ignored while busy", addr_q, 40);
      chk(data_q == old40, "R5 data write ignored while busy", data_q, old40);
      @(negedge clk);
      chk(!ee_req && !burst_q, "R5 no queued request", {ee_req, burst_q}, 0);
      chk(eem[40] == old40, "R5 write request ignored while busy", eem[40], old40);
    end

    // R3 R10 single write with upper data bits set
    host_wr(W_DATA, 32'hABCDEF5A);
    chk(data_q == 8'h5A, "R10 low byte kept", data_q, 8'h5A);
    host_wr(W_ADDR, 30);
    host_wr(W_CTL, 2'b01);
    chk(ctl_q == 2'b01 && ee_we && ee_wdata == 8'h5A && ee_addr == 30, "R3 write issued",
        {ctl_q, ee_we, ee_wdata}, {2'b01, 1'b1, 8'h5A});
    wait_ack("R3 ack");
    @(negedge clk);
    chk(ctl_q == 0, "R3 bit self-clears", ctl_q, 0);
    chk(eem[30] == 8'h5A, "R3 R10 byte written", eem[30], 8'h5A);

    // R4 both bits -> read
    begin
      logic [7:0] old21;
      old21 = eem[21];
      host_wr(W_DATA, 32'h66);
      do_read(16'd21, 2'b11, "R4");
      chk(eem[21] == old21, "R4 no EEPROM write", eem[21], old21);
    end

    // R7 resume after single access; R8 bit 15 / 0x7FFF record; new base
    host_wr(W_BASE, 9'h0F2);
    exp_q.push_back({9'h0F2, 15'h0102, 8'h77});
    exp_q.push_back({9'h0F2, 15'h7FFF, 8'h11});
    burst(16'd22, "R7 resume after single access");
    wait_idle("R6 second burst ends");
    chk(exp_q.size() == 0, "R9 0x7FFF is a record", exp_q.size(), 0);

    // R7 resume after burst terminator
    do_read(16'd100, 2'b10, "R2 second read");
    burst(16'd101, "R7 resume after read at 100");
    wait_idle("R9 empty burst");
    burst(16'd103, "R7 resume after terminator");
    wait_idle("R9 empty burst 2");
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R8 scoreboard drained", exp_q.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule